// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

This block holds four independent down-counting timers that sit inside an interrupt controller and are programmed through a plain register read/write port. Each channel has two registers. The base register holds the reload value and a stop flag. The current register can only be read; it shows the live count and a toggle flag. While a channel is allowed to run, it counts down by one on every tick and reloads when it runs out. On each reload it inverts its toggle flag and drives a one-clock request on its own interrupt output.

The tick is a single-cycle enable that comes from outside the block. It is normally the input clock divided by 4 or by 8. Software starts a channel by clearing the stop flag, which preloads the count from the written value. Software stops a channel by setting the flag, which clears the count but keeps the toggle. Prioritising, routing and acknowledging the interrupts are done by the logic that receives the outputs. Generating the tick is also done outside the block.

Top module: `gtimer_bank`

## Requirements
- R1: After reset every current register reads 0x0000_0000 and every base register reads 0x8000_0000, so every channel is stopped.
- R2: Bits [7:6] of the address select the channel and bits [5:4] select the register: 0 selects current, 1 selects base. The register is decoded only when bits [3:0] are zero. Any other address reads as zero, and writes to it change nothing.
- R3: Writes to a current register have no effect on any register.
- R4: Bit 31 of a base register is the stop flag. While it is 1, the channel's count does not change and its interrupt output stays low.
- R5: A base write that takes bit 31 from 1 to 0 loads the count with bits [30:0] of the written data and leaves the toggle unchanged. Counting starts from the next tick. A tick in the same clock as this write is ignored for that channel.
- R6: A base write that takes bit 31 from 0 to 1 clears the count to zero and keeps the toggle. This write wins over an expiry in the same clock, so no pulse is raised for it.
- R7: On each tick, a running channel whose count is above 1 decrements. A running channel whose count is 0 or 1 reloads from base bits [30:0], inverts its toggle and pulses its interrupt. The period is therefore max(N,1) ticks, and a base of zero gives a pulse on every tick.
- R8: A read of a current register returns the toggle in bit 31 and the live count in bits [30:0].
- R9: An interrupt pulse lasts one clock, appears in the clock after the tick that caused it, and goes only to the output bit of its own channel (bit i for channel i).
- R10: A base write that leaves bit 31 unchanged replaces the stored base value only. The running count carries on, and the new value is used at the next reload.
- R11: The count changes only in clocks where the tick enable is high. No amount of idle clocks alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Register address (channel, register, alignment bits) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| tickEn | input | 1 | One-clock count enable, typically clock/4 or clock/8 |
| timerIrq | output | 4 | Per-channel one-clock interrupt pulse |

## Verification
A base-register write that changes the stop flag can land in the same clock as a tick that would make that channel expire or decrement. The bench steps a channel until its count is exactly 1 and then issues a stopping write with the tick held high in that clock. It then checks that no pulse appears, that the count reads zero and that the toggle is unchanged. A starting write is also issued together with a tick, and the bench checks that the loaded value is read back undecremented. Meanwhile the other channels are still ticking, and their expected pulses must arrive as predicted.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = DATA_W - 1;
  localparam int CH_W    = 2;
  localparam int NUM_CH  = 1 << CH_W;
  localparam int ADDR_W  = 8;
  localparam int OFF_W   = 2;
  localparam int LOW_W   = ADDR_W - CH_W - OFF_W;
  localparam logic [OFF_W-1:0] OFF_CUR  = 2'd0;
  localparam logic [OFF_W-1:0] OFF_BASE = 2'd1;
  localparam logic [DATA_W-1:0] BASE_RESET = {1'b1, {CNT_W{1'b0}}};

  // Strobes from control to datapath, one bit per channel.
  typedef struct packed {
    logic [NUM_CH-1:0] loadBase;
    logic [NUM_CH-1:0] start;
    logic [NUM_CH-1:0] stop;
    logic [DATA_W-1:0] wrData;
  } tmrStrobe_t;
endpackage

// File: rtl/gtimer_ctrl.sv
module gtimer_ctrl
  import gtimer_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] baseReg [NUM_CH],
  input  logic [DATA_W-1:0] curReg  [NUM_CH],
  output tmrStrobe_t        strb,
  output logic [DATA_W-1:0] busRdData
);
  logic [CH_W-1:0]  chSel;
  logic [OFF_W-1:0] offSel;
  logic             aligned;
  logic             oldStop;
  logic             newStop;

  assign chSel   = busAddr[ADDR_W-1 -: CH_W];
  assign offSel  = busAddr[ADDR_W-CH_W-1 -: OFF_W];
  assign aligned = (busAddr[LOW_W-1:0] == '0);
  assign oldStop = baseReg[chSel][DATA_W-1];
  assign newStop = busWrData[DATA_W-1];

  // Decode writes into per-channel strobes; only flag transitions start/stop.
  always_comb begin
    strb        = '0;
    strb.wrData = busWrData;
    if (busWrEn && aligned && offSel == OFF_BASE) begin
      strb.loadBase[chSel] = 1'b1;
      if (oldStop && !newStop) strb.start[chSel] = 1'b1;
      if (!oldStop && newStop) strb.stop[chSel]  = 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    if (aligned) begin
      case (offSel)
        OFF_CUR:  busRdData = curReg[chSel];
        OFF_BASE: busRdData = baseReg[chSel];
        default:  busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/gtimer_datapath.sv
module gtimer_datapath
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tmrStrobe_t        strb,
  output logic [DATA_W-1:0] baseReg [NUM_CH],
  output logic [DATA_W-1:0] curReg  [NUM_CH],
  output logic [NUM_CH-1:0] timerIrq
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] baseVal;
    logic [CNT_W-1:0]  cntVal;
    logic              togBit;
    logic              pulse;
    logic              running;
    logic              lastTick;

    assign running  = !baseVal[DATA_W-1];
    assign lastTick = (cntVal <= CNT_W'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseVal <= BASE_RESET;
        cntVal  <= '0;
        togBit  <= 1'b0;
        pulse   <= 1'b0;
      end else begin
        pulse <= 1'b0;
        if (strb.loadBase[ch]) baseVal <= strb.wrData;
        if (strb.stop[ch]) begin
          cntVal <= '0;
        end else if (strb.start[ch]) begin
          cntVal <= strb.wrData[CNT_W-1:0];
        end else if (running && tickEn) begin
          if (lastTick) begin
            cntVal <= baseVal[CNT_W-1:0];
            togBit <= ~togBit;
            pulse  <= 1'b1;
          end else begin
            cntVal <= cntVal - 1'b1;
          end
        end
      end
    end

    assign baseReg[ch]  = baseVal;
    assign curReg[ch]   = {togBit, cntVal};
    assign timerIrq[ch] = pulse;
  end
endmodule

// File: rtl/gtimer_bank.sv
module gtimer_bank
  import gtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              tickEn,
  output logic [NUM_CH-1:0] timerIrq
);
  tmrStrobe_t        strb;
  logic [DATA_W-1:0] baseReg [NUM_CH];
  logic [DATA_W-1:0] curReg  [NUM_CH];

  gtimer_ctrl u_ctrl (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .baseReg   (baseReg),
    .curReg    (curReg),
    .strb      (strb),
    .busRdData (busRdData)
  );

  gtimer_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strb     (strb),
    .baseReg  (baseReg),
    .curReg   (curReg),
    .timerIrq (timerIrq)
  );
endmodule

// File: rtl/gtimer_chk.sv
module gtimer_chk
  import gtimer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              tickEn,
  input logic [NUM_CH-1:0] timerIrq,
  input logic [DATA_W-1:0] baseRegs [NUM_CH],
  input logic [DATA_W-1:0] curRegs  [NUM_CH]
);
  logic curWrite;
  assign curWrite = busWrEn && busAddr[ADDR_W-CH_W-1 -: OFF_W] == OFF_CUR
                    && busAddr[LOW_W-1:0] == '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic baseHit;
    assign baseHit = busWrEn && busAddr[ADDR_W-1 -: CH_W] == CH_W'(g)
                     && busAddr[ADDR_W-CH_W-1 -: OFF_W] == OFF_BASE
                     && busAddr[LOW_W-1:0] == '0;

    AST_PULSE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
      timerIrq[g] |-> $past(tickEn)); // R9

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      $past(baseRegs[g][DATA_W-1]) |-> !timerIrq[g]); // R4

    AST_START_PRELOAD: assert property (@(posedge clk) disable iff (!rstN)
      (baseHit && baseRegs[g][DATA_W-1] && !busWrData[DATA_W-1])
      |=> curRegs[g][CNT_W-1:0] == $past(busWrData[CNT_W-1:0])); // R5

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (baseHit && !baseRegs[g][DATA_W-1] && busWrData[DATA_W-1])
      |=> curRegs[g][CNT_W-1:0] == '0 && !timerIrq[g]
          && curRegs[g][DATA_W-1] == $past(curRegs[g][DATA_W-1])); // R6

    AST_CUR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
      (curWrite && !tickEn) |=> $stable(curRegs[g]) && $stable(baseRegs[g])); // R3
  end
endmodule

bind gtimer_bank gtimer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .tickEn    (tickEn),
  .timerIrq  (timerIrq),
  .baseRegs  (baseReg),
  .curRegs   (curReg)
);

// File: tb/sim_gtimer_bank.sv
module sim_gtimer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  timerIrq;

  gtimer_bank u0 (.clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
                  .busWrData(busWrData), .busRdData(busRdData), .tickEn(tickEn),
                  .timerIrq(timerIrq));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  typedef struct { int cy; logic [3:0] mask; } expItem_t;
  expItem_t expQ[$];

  // Reference state built from the requirements.
  logic [30:0] mCnt [4];
  logic        mTog [4];
  logic [31:0] mBase [4];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    while (expQ.size() > 0) begin
      expItem_t it = expQ.pop_front();
      chk("R9 missing pulse", 32'(0), 32'(it.mask));
    end
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  // Monitor: pops expected pulse masks and compares with the outputs.
  always @(negedge clk) begin
    logic [3:0] e;
    e = '0;
    if (rstN && !done) begin
      while (expQ.size() > 0 && expQ[0].cy < cyc) begin
        expItem_t it = expQ.pop_front();
        chk("R9 late pulse", 32'(0), 32'(it.mask));
      end
      if (expQ.size() > 0 && expQ[0].cy == cyc) e = expQ.pop_front().mask;
      if (e != 0 || timerIrq != 0) chk("R7 R9 irq", 32'(timerIrq), 32'(e));
    end
  end

  // Advance the model by one tick, skipping channels in skipMask.
  task automatic tickModel(logic [3:0] skipMask);
    logic [3:0] m = '0;
    for (int ch = 0; ch < 4; ch++) begin
      if (!mBase[ch][31] && !skipMask[ch]) begin
        if (mCnt[ch] <= 31'd1) begin
          mCnt[ch] = mBase[ch][30:0];
          mTog[ch] = ~mTog[ch];
          m[ch] = 1'b1;
        end else begin
          mCnt[ch] = mCnt[ch] - 31'd1;
        end
      end
    end
    if (m != 0) expQ.push_back('{cyc + 1, m});
  endtask

  task automatic doTicks(int n, int div);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tickEn = 1'b1;
      tickModel(4'b0);
      @(negedge clk);
      tickEn = 1'b0;
      repeat (div - 2) @(negedge clk);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d, bit withTick);
    logic [3:0] skip = '0;
    int ch = int'(a[7:6]);
    bit isBase = (a[5:4] == 2'd1) && (a[3:0] == 4'd0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    if (isBase) begin
      if (mBase[ch][31] && !d[31]) begin mCnt[ch] = d[30:0]; skip[ch] = 1'b1; end
      else if (!mBase[ch][31] && d[31]) begin mCnt[ch] = '0; skip[ch] = 1'b1; end
    end
    if (withTick) begin
      tickEn = 1'b1;
      tickModel(skip);
    end
    if (isBase) mBase[ch] = d;
    @(negedge clk);
    busWrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic rdChk(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    busAddr = a;
    #1 chk(req, busRdData, exp);
  endtask

  task automatic rdModel(int ch, string req);
    rdChk(8'(ch << 6), {mTog[ch], mCnt[ch]}, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      finishRun();
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin
      mCnt[ch] = '0; mTog[ch] = 1'b0; mBase[ch] = 32'h8000_0000;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int ch = 0; ch < 4; ch++) begin
      rdChk(8'(ch << 6), 32'h0000_0000, "R1 current");
      rdChk(8'((ch << 6) | 8'h10), 32'h8000_0000, "R1 base");
    end

    wrReg(8'h40, 32'h0000_1234, 0);
    rdChk(8'h40, 32'h0, "R3 current write ignored");
    rdChk(8'h50, 32'h8000_0000, "R3 base untouched");

    wrReg(8'h60, 32'h0000_0005, 0);
    rdChk(8'h60, 32'h0, "R2 unused offset reads zero");
    rdChk(8'h50, 32'h8000_0000, "R2 unused offset write ignored");
    wrReg(8'h54, 32'h0000_0003, 0);
    rdChk(8'h50, 32'h8000_0000, "R2 unaligned write ignored");

    doTicks(3, 4);
    rdChk(8'h00, 32'h0, "R4 stopped channel holds");

    wrReg(8'h10, 32'h0000_0005, 0);
    rdChk(8'h00, 32'h0000_0005, "R5 preload");
    doTicks(2, 4);
    rdChk(8'h00, 32'h0000_0003, "R7 R8 live count");
    doTicks(3, 4);
    rdChk(8'h00, 32'h8000_0005, "R7 R8 reload and toggle");

    wrReg(8'h10, 32'h0000_0002, 0);
    rdChk(8'h00, 32'h8000_0005, "R10 count continues");
    doTicks(5, 8);
    rdModel(0, "R10 new base at reload");

    wrReg(8'h90, 32'h0000_0000, 0);
    doTicks(4, 4);
    rdModel(2, "R7 zero base every tick");

    wrReg(8'hD0, 32'h0000_0003, 0);
    doTicks(10, 8);
    for (int ch = 0; ch < 4; ch++) rdModel(ch, "R7 multi-channel");

    wrReg(8'h90, 32'h8000_0000, 0);
    rdModel(2, "R6 stop keeps toggle");

    while (mCnt[0] != 31'd1) doTicks(1, 4);
    wrReg(8'h10, 32'h8000_0002, 1);
    rdModel(0, "R6 stop beats expiry");

    wrReg(8'h90, 32'h0000_0007, 1);
    rdChk(8'h80, {mTog[2], 31'd7}, "R5 start ignores same-cycle tick");

    repeat (20) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) rdModel(ch, "R11 idle clocks");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule